// File: doc/BRIEF.md
# System Control Register A

This block is a single 8-bit system control register on the I/O bus. It holds the gate that lets address line 20 reach memory, a lock that closes the password storage once closed, and a two-bit code that drives the disk-activity indicator. It also reports the state of a watchdog timeout input, and it fires a CPU reset pulse of fixed width when software asks for one.

The register answers only while its visibility input `port_en` is high. A write is a one-cycle strobe with data. A read returns the register image combinationally. When the port is hidden, writes are dropped and the read bus returns all ones, as a floating bus would.

Bit positions matter because software uses read-modify-write on this register:

| Bit | Role |
|-----|------|
| 0 | write 1 to request a reset pulse; reads 0 |
| 1 | A20 gate |
| 2 | reserved, reads 0 |
| 3 | password lock |
| 4 | watchdog status, read-only |
| 5 | reserved, reads 0 |
| 7:6 | indicator code |

Top module: `sys_ctrl_port_a`

## Requirements
- R1: After reset the A20 gate, the lock, the indicator code and the reset pulse are all 0. An enabled read with the watchdog input low returns 0x00.
- R2: Bit 1 is read/write and sets the A20 gate: 0 blocks, 1 passes. `a20_gate` and read bit 1 follow the last enabled write, starting one cycle after the write strobe.
- R3: An enabled write with bit 0 = 1 raises `cpu_reset` on the next cycle. The pulse holds for exactly PULSE_CYCLES cycles. A write with bit 0 = 0 gives no pulse.
- R4: A bit-0 request made while a pulse is running is ignored. The pulse neither restarts nor stretches.
- R5: Bit 3 is the password lock, and writes can only set it. Writing 1 sets it. Writing 0 does not clear it. Only reset clears it.
- R6: Bits 7:6 hold the indicator code and read back as written. `led_on` is 1 for codes 01, 10 and 11, and 0 for code 00.
- R7: Read bit 4 shows the `wdog_timeout` input. Writing bit 4 changes no state.
- R8: Bits 0, 2 and 5 always read 0. Writes to bits 2 and 5 have no effect.
- R9: While `port_en` is 0, writes change nothing (including the reset pulse), and `rd_data` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| port_en | input | 1 | makes the register visible |
| wr_stb | input | 1 | write strobe, one cycle |
| wr_data | input | 8 | write data |
| wdog_timeout | input | 1 | watchdog timeout status |
| rd_data | output | 8 | read image, 0xFF when hidden |
| a20_gate | output | 1 | A20 pass enable |
| cpu_reset | output | 1 | fast CPU reset pulse |
| pw_lock | output | 1 | password storage locked |
| led_code | output | 2 | indicator code |
| led_on | output | 1 | indicator lit |

## Verification
Each stored field appears both on its own output and in the read image. A wrong internal state therefore shows on two ports one cycle after the write that caused it.

A pulse counter that starts at the wrong value, restarts when it should not, or fails to stop would make `cpu_reset` differ from the reference within PULSE_CYCLES+1 cycles of the request.

A lock that can be cleared, or a hidden port that still accepts writes, is found one cycle after the offending write. The bench compares against its model on every clock.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_RST   = 0;
  localparam int BIT_A20   = 1;
  localparam int BIT_LOCK  = 3;
  localparam int BIT_WDOG  = 4;
  localparam int LED_LSB   = 6;
  localparam int LED_W     = 2;
  localparam logic [REG_W-1:0] HIDDEN_READ = '1;

  typedef struct packed {
    logic             a20;
    logic             lock;
    logic [LED_W-1:0] led;
  } ctrl_state_t;
endpackage

// File: rtl/scpa_rst_sync.sv
module scpa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/scpa_pulse_gen.sv
module scpa_pulse_gen #(
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end else if (trig) begin
      cnt_d  = CNT_LOAD;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/scpa_ctrl_regs.sv
module scpa_ctrl_regs
  import sys_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_state_t      state
);
  ctrl_state_t state_q, state_d;

  always_comb begin
    state_d      = state_q;
    state_d.a20  = wr_data[BIT_A20];
    state_d.lock = state_q.lock | wr_data[BIT_LOCK];
    state_d.led  = wr_data[LED_LSB +: LED_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= '0;
    else if (wr_stb) state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sys_ctrl_port_a.sv
module sys_ctrl_port_a
  import sys_ctrl_pkg::*;
#(
  parameter int PULSE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       wdog_timeout,
  output logic [7:0] rd_data,
  output logic       a20_gate,
  output logic       cpu_reset,
  output logic       pw_lock,
  output logic [1:0] led_code,
  output logic       led_on
);
  logic        rst_int_n;
  logic        wr_ok;
  ctrl_state_t st;
  logic [REG_W-1:0] image;

  scpa_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  assign wr_ok = port_en & wr_stb;

  scpa_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_stb(wr_ok), .wr_data(wr_data), .state(st)
  );

  scpa_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_int_n), .trig(wr_ok & wr_data[BIT_RST]), .active(cpu_reset)
  );

  always_comb begin
    image                        = '0;
    image[BIT_A20]               = st.a20;
    image[BIT_LOCK]              = st.lock;
    image[BIT_WDOG]              = wdog_timeout;
    image[LED_LSB +: LED_W]      = st.led;
  end

  assign rd_data  = port_en ? image : HIDDEN_READ;
  assign a20_gate = st.a20;
  assign pw_lock  = st.lock;
  assign led_code = st.led;
  assign led_on   = |st.led;
endmodule

// File: rtl/sys_ctrl_port_a_chk.sv
module sys_ctrl_port_a_chk #(
  parameter int PULSE_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       a20_gate,
  input logic       cpu_reset,
  input logic       pw_lock,
  input logic [1:0] led_code,
  input logic       led_on
);
  int unsigned hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run <= 0;
    else if (cpu_reset) hi_run <= hi_run + 1;
    else                hi_run <= 0;
  end

  assert_a20_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && wr_stb && $past(rst_n)) |=> (a20_gate == $past(wr_data[1])));

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= PULSE_CYCLES);

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pw_lock |=> pw_lock);

  assert_led_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |-> (led_on == (rd_data[7:6] != 2'b00)));

  assert_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |-> (rd_data[0] == 1'b0 && rd_data[2] == 1'b0 && rd_data[5] == 1'b0));

  assert_hidden_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !cpu_reset) |=> ($stable({a20_gate, pw_lock, led_code}) && !cpu_reset));
endmodule

bind sys_ctrl_port_a sys_ctrl_port_a_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_stb(wr_stb), .wr_data(wr_data),
  .rd_data(rd_data), .a20_gate(a20_gate), .cpu_reset(cpu_reset), .pw_lock(pw_lock),
  .led_code(led_code), .led_on(led_on)
);

// File: tb/sys_ctrl_port_a_tb.sv
module sys_ctrl_port_a_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wdog_timeout = 1'b0;
  logic [7:0] rd_data;
  logic       a20_gate, cpu_reset, pw_lock, led_on;
  logic [1:0] led_code;

  int n_checks = 0;
  int n_fail   = 0;

  logic       m_a20, m_lock;
  logic [1:0] m_led;
  int         m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_ctrl_port_a #(.PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .wdog_timeout(wdog_timeout), .rd_data(rd_data), .a20_gate(a20_gate),
    .cpu_reset(cpu_reset), .pw_lock(pw_lock), .led_code(led_code), .led_on(led_on)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a20 = 1'b0; m_lock = 1'b0; m_led = 2'b00; m_cnt = 0;
    end else begin
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      else if (port_en && wr_stb && wr_data[0]) m_cnt = PULSE;
      if (port_en && wr_stb) begin
        m_a20 = wr_data[1];
        if (wr_data[3]) m_lock = 1'b1;
        m_led = wr_data[7:6];
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [7:0] exp_rd;
    exp_rd = port_en ? {m_led, 1'b0, wdog_timeout, m_lock, 1'b0, m_a20, 1'b0} : 8'hFF;
    check("R2 a20_gate", a20_gate, m_a20);
    check("R3 R4 cpu_reset", cpu_reset, m_cnt > 0);
    check("R5 pw_lock", pw_lock, m_lock);
    check("R6 led_code", led_code, m_led);
    check("R6 led_on", led_on, m_led != 2'b00);
    check("R7 R8 R9 rd_data", rd_data, exp_rd);
  endtask

  // one clock: drive after the falling edge, compare just before the next one
  task automatic step(input logic en, input logic we, input logic [7:0] d, input logic wd);
    @(negedge clk);
    port_en = en; wr_stb = we; wr_data = d; wdog_timeout = wd;
    #1 compare_all();
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, 1'b1, d, wdog_timeout);
    step(1'b1, 1'b0, 8'h00, wdog_timeout);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b1, 1'b0, 8'h00, 1'b0);
    // R1 reset state
    check("R1 rd_data after reset", rd_data, 8'h00);
    check("R1 outputs after reset", {a20_gate, cpu_reset, pw_lock, led_code}, 0);

    // R2 gate on, then off
    wr(8'h02);
    check("R2 gate on", a20_gate, 1);
    wr(8'h00);
    check("R2 gate off", a20_gate, 0);

    // R6 each indicator code
    for (int c = 0; c < 4; c++) begin
      wr(8'(c << 6));
      check("R6 code readback", rd_data[7:6], c);
      check("R6 lit", led_on, c != 0);
    end

    // R7 watchdog visible, write to bit 4 ignored
    step(1'b1, 1'b0, 8'h00, 1'b1);
    check("R7 wdog read", rd_data[4], 1);
    wr(8'h10);
    step(1'b1, 1'b0, 8'h00, 1'b0);
    check("R7 wdog write ignored", rd_data, 8'h00);

    // R8 reserved bits
    wr(8'h24);
    check("R8 reserved read zero", rd_data, 8'h00);

    // R3 single pulse, and no pulse for bit0=0
    wr(8'h00);
    check("R3 no pulse on zero", cpu_reset, 0);
    begin
      int highs = 0;
      step(1'b1, 1'b1, 8'h01, 1'b0);
      for (int i = 0; i < PULSE + 4; i++) begin
        step(1'b1, 1'b0, 8'h00, 1'b0);
        if (cpu_reset) highs++;
      end
      check("R3 pulse width", highs, PULSE);
    end

    // R4 retrigger during pulse ignored
    begin
      int highs = 0;
      step(1'b1, 1'b1, 8'h01, 1'b0);
      for (int i = 0; i < PULSE + 6; i++) begin
        step(1'b1, (i == 2), 8'h01, 1'b0);
        if (cpu_reset) highs++;
      end
      check("R4 no retrigger", highs, PULSE);
    end

    // R5 lock set-only
    wr(8'h08);
    check("R5 lock set", pw_lock, 1);
    wr(8'h00);
    check("R5 lock stays", pw_lock, 1);
    wr(8'hC2);
    check("R5 lock with other bits", rd_data, 8'hCA);

    // R9 hidden port
    step(1'b0, 1'b1, 8'h01, 1'b0);
    check("R9 hidden read", rd_data, 8'hFF);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    check("R9 hidden no pulse", cpu_reset, 0);
    step(1'b1, 1'b0, 8'h00, 1'b0);
    check("R9 hidden write ignored", rd_data, 8'hCA);

    // R1 reset clears the lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(1'b1, 1'b0, 8'h00, 1'b0);
    check("R1 lock cleared by reset", rd_data, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule